// File: doc/BRIEF.md
# Tone and Alarm Sound Generator

This block drives a one-bit speaker line from one of two sources. The first is a programmable tone generator. A selectable prescaler feeds an 8-bit down-counter that reloads from a divider register, and a divide-by-four stage after the counter produces a square wave of `f_pre / (N+1) / 4`. The second source is a fixed alarm tone taken from the slow reference clock. It runs at a selectable 2 kHz or 4 kHz when the reference is 32.768 kHz. It can be silenced, played without a break, or gated by a fixed on/off envelope window.

All logic runs on the system clock. The reference clock enters as a plain input, passes through a two-stage synchronizer and is turned into a one-cycle tick on each of its rising edges. Software sets up the block through a write-only port with three registers. It chooses the source, the prescaler code, the divider value, the alarm frequency and mode, a tone enable and a force-high override. The speaker output is registered.

Top module: `tone_alarm_sound`

## Requirements
- R1: Register 0 bits [2:0] select the tone clock. Code 0 uses one tick per synchronized reference rising edge. Codes 1 to 7 use one tick every 4, 8, 16, 32, 64, 128 and 256 system clocks.
- R2: With the tone generator selected and enabled, the speaker is a square wave whose period is 4·(N+1) prescaled ticks. N is register 1.
- R3: Every divider value from 1 to 255 gives the R2 period, including both ends of the range. Writing 0 to register 1 is a usage error.
- R4: Register 2 bit 0 picks the alarm frequency. A 0 gives one period per 16 reference ticks (2 kHz from 32.768 kHz). A 1 gives one period per 8 reference ticks (4 kHz).
- R5: Register 2 bits [2:1] set the alarm mode. Codes 00 and 01 keep the alarm output low. Code 11 plays the alarm tone without a break.
- R6: Alarm mode 10 passes the alarm tone for ENV_ON reference ticks and then holds it low for ENV_OFF ticks, repeating. With the defaults (64/64) this is 4 rising edges per 1024 system clocks at 2 kHz and 8 at 4 kHz, for a 125 MHz bench clock and a reference tick every 8 clocks.
- R7: Register 0 bit 5 picks the speaker source: 0 for the alarm path, 1 for the tone path.
- R8: Register 0 bit 3 enables the tone generator. While it is 0 the tone path stays low and its counters are cleared.
- R9: Register 0 bit 4, with the tone path selected, holds the speaker high whatever the enable. It has no effect while the alarm path is selected.
- R10: A new divider value takes effect at the next counter reload. No half-period after the write is shorter than 2·(N_old+1) ticks, and later half-periods are 2·(N_new+1) ticks.
- R11: After reset every control field is 0, so the alarm path is selected with its mode off and the speaker stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_clk | input | 1 | Slow reference clock, sampled and synchronized |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 tone config, 1 divider, 2 alarm config |
| wr_data | input | 8 | Write data |
| speaker | output | 1 | Registered one-bit speaker drive |

## Verification
The assertions assume that the divider register is never written with zero. They also assume the reference clock is slow enough that its synchronized rising edges never land on consecutive system cycles. The bench writes only divider values between 1 and 255. It toggles the reference every four system clocks, so the reference is far slower than the synchronizer. The bench disables the tone path before each new divider and prescaler setting, so every period it measures starts from cleared counters. Only the divider-change test rewrites the value while the tone is running.

// File: rtl/sg_pkg.sv
// Shared register addresses, field types and the decoded control record.
package sg_pkg;
    localparam int ADDR_W = 2;
    localparam int DATA_W = 8;
    localparam int SEL_W  = 3;
    localparam int DIV_W  = 8;

    localparam logic [ADDR_W-1:0] A_TONE  = 2'd0;
    localparam logic [ADDR_W-1:0] A_DIV   = 2'd1;
    localparam logic [ADDR_W-1:0] A_ALARM = 2'd2;

    typedef enum logic [1:0] {
        AM_OFF0  = 2'b00,
        AM_OFF1  = 2'b01,
        AM_GATED = 2'b10,
        AM_CONT  = 2'b11
    } alarm_mode_e;

    typedef struct packed {
        logic [SEL_W-1:0] presc_sel;
        logic             tone_en;
        logic             force_hi;
        logic             src_tone;
        logic [DIV_W-1:0] div_n;
        logic             alarm_4k;
        alarm_mode_e      alarm_mode;
    } sg_cfg_t;
endpackage

// File: rtl/sg_regs.sv
// Control register file. Write-only, so it has no read path.
// Assumes a write strobe lasts one cycle per write. Every field resets to zero.
module sg_regs
    import sg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output sg_cfg_t           cfg
);
    // Capture writes into the decoded control record.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                A_TONE: begin
                    cfg.presc_sel <= wr_data[SEL_W-1:0];
                    cfg.tone_en   <= wr_data[3];
                    cfg.force_hi  <= wr_data[4];
                    cfg.src_tone  <= wr_data[5];
                end
                A_DIV:   cfg.div_n <= wr_data[DIV_W-1:0];
                A_ALARM: begin
                    cfg.alarm_4k   <= wr_data[0];
                    cfg.alarm_mode <= alarm_mode_e'(wr_data[2:1]);
                end
                default: ;
            endcase
        end
    end

    // R3
    div_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_DIV) |-> (wr_data != '0));
endmodule

// File: rtl/sg_prescale.sv
// Tone clock prescaler. Code 0 passes the reference tick through. Code k>0
// fires once every 2^(k+1) system cycles from a free-running counter.
// Assumes the reference tick is already a one-cycle pulse.
module sg_prescale #(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_tick,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int NCODE = 1 << SEL_W;
    localparam int CNT_W = NCODE;

    logic [CNT_W-1:0] cnt;
    logic [NCODE-1:0] taps;

    // Free-running divide chain shared by all system-clock taps.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= cnt + 1'b1;
    end

    assign taps[0] = ref_tick;
    generate
        for (genvar k = 1; k < NCODE; k++) begin : g_tap
            assign taps[k] = &cnt[k:0];
        end
    endgenerate

    assign tick = taps[sel];

    // R1
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel != '0 && tick) |=> (!tick || sel != $past(sel)));
endmodule

// File: rtl/sg_tone.sv
// Programmable tone: a reload down-counter of N+1 ticks, then divide by 4.
// The divider is sampled only at reload. A disable clears both stages.
module sg_tone #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             tick,
    input  logic [DIV_W-1:0] div_n,
    output logic             tone
);
    logic [DIV_W-1:0] cnt;
    logic [1:0]       quad;

    // Count ticks down and advance the quarter-phase counter at each reload.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            quad <= '0;
        end else if (!en) begin
            cnt  <= '0;
            quad <= '0;
        end else if (tick) begin
            if (cnt == '0) begin
                cnt  <= div_n;
                quad <= quad + 1'b1;
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    assign tone = quad[1];

    // R2
    count_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && tick && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
    // R10
    reload_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && tick && cnt == '0) |=> (cnt == $past(div_n)));
    // R8
    disabled_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !tone);
endmodule

// File: rtl/sg_alarm.sv
// Fixed alarm tone from the reference tick. The top bit of the counter
// gives ref/16 and the next bit gives ref/8. An envelope window of
// ENV_ON + ENV_OFF ticks gates the tone in mode 10.
module sg_alarm
    import sg_pkg::*;
#(
    parameter int ALM_W   = 4,
    parameter int ENV_ON  = 64,
    parameter int ENV_OFF = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ref_tick,
    input  logic        base_4k,
    input  alarm_mode_e mode,
    output logic        alarm
);
    localparam int TAP_SLOW = ALM_W - 1;
    localparam int TAP_FAST = ALM_W - 2;
    localparam int ENV_LEN  = ENV_ON + ENV_OFF;
    localparam int ENV_W    = $clog2(ENV_LEN);

    logic [ALM_W-1:0] acnt;
    logic [ENV_W-1:0] env;
    logic             gate;
    logic             base_wave;

    // Advance the alarm divider and envelope position once per reference tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acnt <= '0;
            env  <= '0;
        end else if (ref_tick) begin
            acnt <= acnt + 1'b1;
            env  <= (env == ENV_W'(ENV_LEN - 1)) ? '0 : env + 1'b1;
        end
    end

    assign gate      = (env < ENV_W'(ENV_ON));
    assign base_wave = base_4k ? acnt[TAP_FAST] : acnt[TAP_SLOW];

    // Apply the alarm mode to the base tone.
    always_comb begin
        case (mode)
            AM_GATED: alarm = base_wave & gate;
            AM_CONT:  alarm = base_wave;
            default:  alarm = 1'b0;
        endcase
    end

    // R4
    ref_paced_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ref_tick |=> $stable(acnt));
endmodule

// File: rtl/tone_alarm_sound.sv
// Top level: synchronizes the reference clock into a tick, holds the
// registers, and selects between the tone and alarm paths with a force-high
// override. The speaker output is registered.
// Assumes the reference clock is much slower than clk.
module tone_alarm_sound
    import sg_pkg::*;
#(
    parameter int ENV_ON  = 64,
    parameter int ENV_OFF = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              speaker
);
    sg_cfg_t    cfg;
    logic [2:0] ref_sync;
    logic       ref_tick;
    logic       pre_tick;
    logic       tone;
    logic       alarm;
    logic       mux_out;

    // Two-stage synchronizer plus one stage for rising-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) ref_sync <= '0;
        else        ref_sync <= {ref_sync[1:0], ref_clk};
    end
    assign ref_tick = ref_sync[1] & ~ref_sync[2];

    sg_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .cfg(cfg)
    );

    sg_prescale #(.SEL_W(SEL_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick),
        .sel(cfg.presc_sel), .tick(pre_tick)
    );

    sg_tone #(.DIV_W(DIV_W)) u_tone (
        .clk(clk), .rst_n(rst_n), .en(cfg.tone_en), .tick(pre_tick),
        .div_n(cfg.div_n), .tone(tone)
    );

    sg_alarm #(.ALM_W(4), .ENV_ON(ENV_ON), .ENV_OFF(ENV_OFF)) u_alarm (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick),
        .base_4k(cfg.alarm_4k), .mode(cfg.alarm_mode), .alarm(alarm)
    );

    // Source select with the force-high override on the tone side.
    always_comb begin
        if (cfg.src_tone) mux_out = cfg.force_hi | tone;
        else              mux_out = alarm;
    end

    // Register the speaker drive.
    always_ff @(posedge clk) begin
        if (!rst_n) speaker <= 1'b0;
        else        speaker <= mux_out;
    end

    // R9
    force_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.src_tone && cfg.force_hi) |=> speaker);
    // R5
    alarm_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg.src_tone && !cfg.alarm_mode[1]) |=> !speaker);
    // R8
    tone_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.src_tone && !cfg.force_hi && !cfg.tone_en && $past(!cfg.tone_en))
        |=> !speaker);
    // R1
    ref_tick_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ref_tick |=> !ref_tick);
endmodule

// File: tb/sim_tone_alarm_sound.sv
module sim_tone_alarm_sound;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_clk = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       speaker;

    int n_chk  = 0;
    int n_fail = 0;
    int refdiv = 0;

    localparam int LIMIT = 20000;

    tone_alarm_sound u0 (
        .clk(clk), .rst_n(rst_n), .ref_clk(ref_clk), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .speaker(speaker)
    );

    always #4 clk = ~clk;

    // Reference clock: toggles every 4 system clocks, so one tick per 8 clocks.
    always @(negedge clk) begin
        refdiv <= (refdiv == 3) ? 0 : refdiv + 1;
        if (refdiv == 3) ref_clk <= ~ref_clk;
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic chk_rng(input string tag, input int act, input int lo, input int hi);
        n_chk++;
        if (act < lo || act > hi) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d..%0d", tag, act, lo, hi);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    function automatic logic [7:0] tcfg(input int sel, input bit en, input bit frc, input bit src);
        return {2'b00, src, frc, en, 3'(sel)};
    endfunction

    function automatic logic [7:0] acfg(input int mode, input bit fast);
        return {5'b0, 2'(mode), fast};
    endfunction

    // Cycles until the next rising edge of the speaker, or -1 on timeout.
    task automatic to_rise(output int cyc);
        logic prev;
        prev = speaker;
        cyc = 0;
        while (1) begin
            @(negedge clk);
            cyc++;
            if (!prev && speaker) break;
            prev = speaker;
            if (cyc > LIMIT) begin cyc = -1; break; end
        end
    endtask

    // Cycles until the speaker changes level, or -1 on timeout.
    task automatic to_change(output int cyc);
        logic prev;
        prev = speaker;
        cyc = 0;
        while (1) begin
            @(negedge clk);
            cyc++;
            if (prev != speaker) break;
            if (cyc > LIMIT) begin cyc = -1; break; end
        end
    endtask

    task automatic period(output int p);
        int d;
        to_rise(d);
        to_rise(p);
        if (d < 0) p = -1;
    endtask

    task automatic window(input int n, output int rises, output int highs);
        logic prev;
        rises = 0; highs = 0;
        @(negedge clk);
        prev = speaker;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (!prev && speaker) rises++;
            if (speaker) highs++;
            prev = speaker;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int p, r, h, s;
        int nv[3] = '{1, 2, 4};
        repeat (5) @(negedge clk);
        // R11: reset state
        chk("R11 speaker at reset", int'(speaker), 0);
        rst_n = 1'b1;
        window(1024, r, h);
        chk("R11 silent after reset", h, 0);

        // R1 R2: every prescaler code against several divider values
        for (int sel = 0; sel < 8; sel++) begin
            for (int j = 0; j < 3; j++) begin
                int d;
                d = (sel == 0) ? 8 : (2 << sel);
                wr(2'd0, tcfg(sel, 1'b0, 1'b0, 1'b1));
                wr(2'd1, 8'(nv[j]));
                wr(2'd0, tcfg(sel, 1'b1, 1'b0, 1'b1));
                period(p);
                chk($sformatf("R1 R2 sel %0d N %0d period", sel, nv[j]), p, 4 * (nv[j] + 1) * d);
            end
        end

        // R3: top of the divider range
        wr(2'd0, tcfg(1, 1'b0, 1'b0, 1'b1));
        wr(2'd1, 8'd255);
        wr(2'd0, tcfg(1, 1'b1, 1'b0, 1'b1));
        period(p);
        chk("R3 N 255 period", p, 4 * 256 * 4);

        // R10: divider change while running
        wr(2'd0, tcfg(1, 1'b0, 1'b0, 1'b1));
        wr(2'd1, 8'd3);
        wr(2'd0, tcfg(1, 1'b1, 1'b0, 1'b1));
        period(p);
        chk("R10 old period", p, 64);
        wr(2'd1, 8'd7);
        to_change(s);
        to_change(s);
        chk_rng("R10 first half after write", s, 32, 64);
        to_change(s);
        chk("R10 new half period a", s, 64);
        to_change(s);
        chk("R10 new half period b", s, 64);

        // R8: tone selected but disabled
        wr(2'd0, tcfg(1, 1'b0, 1'b0, 1'b1));
        window(512, r, h);
        chk("R8 disabled tone highs", h, 0);

        // R9: force high, with the tone enabled and disabled
        wr(2'd0, tcfg(1, 1'b1, 1'b1, 1'b1));
        window(512, r, h);
        chk("R9 force enabled highs", h, 512);
        wr(2'd0, tcfg(1, 1'b0, 1'b1, 1'b1));
        window(512, r, h);
        chk("R9 force disabled highs", h, 512);

        // R7: source select with both paths active
        wr(2'd1, 8'd2);
        wr(2'd2, acfg(3, 1'b0));
        wr(2'd0, tcfg(1, 1'b1, 1'b0, 1'b0));
        period(p);
        chk("R7 alarm source period", p, 128);
        wr(2'd0, tcfg(1, 1'b0, 1'b0, 1'b1));
        wr(2'd0, tcfg(1, 1'b1, 1'b0, 1'b1));
        period(p);
        chk("R7 tone source period", p, 4 * 3 * 4);

        // R9: force has no effect on the alarm path
        wr(2'd0, tcfg(1, 1'b1, 1'b1, 1'b0));
        period(p);
        chk("R9 force ignored on alarm", p, 128);

        // R4: alarm base frequencies
        wr(2'd0, tcfg(0, 1'b0, 1'b0, 1'b0));
        wr(2'd2, acfg(3, 1'b0));
        period(p);
        chk("R4 2k alarm period", p, 128);
        wr(2'd2, acfg(3, 1'b1));
        period(p);
        chk("R4 4k alarm period", p, 64);

        // R5: alarm modes off and continuous
        wr(2'd2, acfg(0, 1'b0));
        window(1024, r, h);
        chk("R5 mode 00 highs", h, 0);
        wr(2'd2, acfg(1, 1'b1));
        window(1024, r, h);
        chk("R5 mode 01 highs", h, 0);
        wr(2'd2, acfg(3, 1'b0));
        window(1024, r, h);
        chk("R5 mode 11 rises", r, 8);

        // R6: gated mode
        wr(2'd2, acfg(2, 1'b0));
        window(1024, r, h);
        chk("R6 gated 2k rises", r, 4);
        chk("R6 gated 2k highs", h, 256);
        wr(2'd2, acfg(2, 1'b1));
        window(1024, r, h);
        chk("R6 gated 4k rises", r, 8);
        chk("R6 gated 4k highs", h, 256);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule